// File: doc/BRIEF.md
# Error-Rate Automatic Mute Controller

This block watches the error pulses that an upstream frame decoder raises and totals them over fixed measurement windows, 128 ms by default. The window is timed by counting a tick-enable input. At the end of each window the total is compared with two programmable 8-bit limits. A total at or above the upper limit turns the automatic mute on. A total at or below the lower limit turns it off. A total between the two limits leaves the state as it was, so the two limits form a hysteresis band.

The automatic mute is combined with several other controls to give two registered outputs: a flag that zeroes the digital audio, and a flag that switches the output source to the FM path. The other controls are an active-low external mute pin, an active-low register mute bit, a mode bit that sets what an external or register mute does, a disable bit for the automatic function, and an override that makes the transmitted C4 control bit take part in the decision. The control registers reach the block as plain inputs.

Top module: `amute_ctrl`

## Requirements
- R1: After reset, `auto_muted`, `mute_digital` and `select_fm` are 0, and the error total and window position start from zero.
- R2: A window ends on the `tick_en` pulse that completes WIN_TICKS = TICK_HZ*WINDOW_MS/1000 ticks. `auto_muted` changes only on the clock edge of that closing pulse, or through R7.
- R3: The error total increments by one per clock with `err_pulse` high. It saturates at 2^ERR_W-1 (255 by default) and does not wrap.
- R4: At a window end with `auto_off` low, a total >= `lim_upper` sets `auto_muted`. This takes priority over R5 when both comparisons hold.
- R5: At a window end with `auto_off` low, a total <= `lim_lower` that is below `lim_upper` clears `auto_muted`. A total strictly between the limits keeps the state.
- R6: An `err_pulse` in the same cycle as a window-closing tick counts toward the new window, which then starts at 1 instead of 0.
- R7: While `auto_off` is 1, `auto_muted` is 0 from the next edge. The automatic path then has no effect on either output.
- R8: A mute request is `ext_mute_n` = 0 or `reg_mute_n` = 0. It sets `mute_digital`. It also sets `select_fm` only when `mute_def` = 1.
- R9: `mute_pin_pull` is 1 exactly while `reg_mute_n` is 0. It drives the external mute pin low.
- R10: With `c4_follow` = 1 and `c4_bit` = 0, `select_fm` is set. With `c4_follow` = 0, `c4_bit` has no effect on the outputs.
- R11: `mute_digital` and `select_fm` are registered. Each equals, one cycle later, the OR of its sources: `auto_muted` drives both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timebase tick that advances the measurement window |
| err_pulse | input | 1 | One decoding error in this cycle |
| lim_upper | input | ERR_W | Engage limit (software default 0x50) |
| lim_lower | input | ERR_W | Release limit (software default 0x14) |
| auto_off | input | 1 | 1 disables the automatic mute |
| ext_mute_n | input | 1 | External mute pin, active low |
| reg_mute_n | input | 1 | Register mute bit, active low |
| mute_def | input | 1 | 1: a mute request also selects the FM path |
| c4_follow | input | 1 | 1: the transmitted C4 bit takes part in muting |
| c4_bit | input | 1 | Transmitted C4 control bit |
| mute_digital | output | 1 | Zero the digital audio data |
| select_fm | output | 1 | Route the FM path to the output |
| auto_muted | output | 1 | Current automatic mute state |
| mute_pin_pull | output | 1 | Pull the external mute pin low |

## Verification
Window error totals are swept from zero up to above the upper limit, starting once from the muted state and once from the unmuted state. This separates the engage threshold, the release threshold and the hold band between them. Two patterns target the counter itself. Errors placed on every cycle of a window, including the closing tick, show whether a boundary error lands in the old window or the new one. A slow timebase carrying 300 errors in one window shows the difference between saturating and wrapping. A walk through every combination of the pin, the register bit, the mode bit and the C4 controls separates their effects on the two outputs. A window checked before its last tick shows that decisions wait for the window boundary.

// File: rtl/amute_pkg.sv
package amute_pkg;

  // Software defaults for the limit registers
  localparam int unsigned DEF_UPPER = 32'h50;
  localparam int unsigned DEF_LOWER = 32'h14;

  typedef struct packed {
    logic mute_digital;
    logic select_fm;
  } amute_out_t;

  // Combine every mute source into the two output flags
  function automatic amute_out_t mix_outputs(
    input logic auto_state,
    input logic req,
    input logic def_fm,
    input logic c4_use,
    input logic c4_val
  );
    amute_out_t o;
    o.mute_digital = auto_state | req;
    o.select_fm    = auto_state | (req & def_fm) | (c4_use & ~c4_val);
    return o;
  endfunction

endpackage

// File: rtl/amute_window.sv
module amute_window #(
  parameter int unsigned WIN_TICKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic win_end
);
  localparam int unsigned TW = $clog2(WIN_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(WIN_TICKS - 1);

  logic [TW-1:0] tpos;

  assign win_end = tick_en && (tpos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpos <= '0;
    end else if (tick_en) begin
      tpos <= win_end ? '0 : tpos + 1'b1;
    end
  end
endmodule

// File: rtl/amute_errcnt.sv
module amute_errcnt #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_pulse,
  input  logic             win_end,
  output logic [ERR_W-1:0] total
);
  localparam logic [ERR_W-1:0] TOP = '1;

  function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
    return (v == TOP) ? TOP : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
    end else if (win_end) begin
      total <= {{(ERR_W-1){1'b0}}, err_pulse};
    end else if (err_pulse) begin
      total <= sat_inc(total);
    end
  end
endmodule

// File: rtl/amute_hyst.sv
module amute_hyst #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic [ERR_W-1:0] total,
  input  logic [ERR_W-1:0] upper,
  input  logic [ERR_W-1:0] lower,
  input  logic             auto_off,
  output logic             state,
  output logic             engage_ev,
  output logic             release_ev
);
  logic over_hi, under_lo;

  assign over_hi    = total >= upper;
  assign under_lo   = (total <= lower) && !over_hi;
  assign engage_ev  = win_end && !auto_off && over_hi && !state;
  assign release_ev = win_end && !auto_off && under_lo && state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= 1'b0;
    end else if (auto_off) begin
      state <= 1'b0;
    end else if (engage_ev) begin
      state <= 1'b1;
    end else if (release_ev) begin
      state <= 1'b0;
    end
  end
endmodule

// File: rtl/amute_ctrl.sv
module amute_ctrl #(
  parameter int unsigned TICK_HZ   = 1000,
  parameter int unsigned WINDOW_MS = 128,
  parameter int unsigned ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             err_pulse,
  input  logic [ERR_W-1:0] lim_upper,
  input  logic [ERR_W-1:0] lim_lower,
  input  logic             auto_off,
  input  logic             ext_mute_n,
  input  logic             reg_mute_n,
  input  logic             mute_def,
  input  logic             c4_follow,
  input  logic             c4_bit,
  output logic             mute_digital,
  output logic             select_fm,
  output logic             auto_muted,
  output logic             mute_pin_pull
);
  import amute_pkg::*;

  localparam int unsigned WIN_RAW   = (TICK_HZ * WINDOW_MS) / 1000;
  localparam int unsigned WIN_TICKS = (WIN_RAW == 0) ? 1 : WIN_RAW;

  logic             win_end;
  logic [ERR_W-1:0] err_cnt;
  logic             engage_ev, release_ev;
  logic             ext_req;
  amute_out_t       mix_nxt, mix_q;

  amute_window #(.WIN_TICKS(WIN_TICKS)) u_window (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .win_end(win_end)
  );

  amute_errcnt #(.ERR_W(ERR_W)) u_errcnt (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse),
    .win_end(win_end), .total(err_cnt)
  );

  amute_hyst #(.ERR_W(ERR_W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .total(err_cnt),
    .upper(lim_upper), .lower(lim_lower), .auto_off(auto_off),
    .state(auto_muted), .engage_ev(engage_ev), .release_ev(release_ev)
  );

  assign ext_req = ~ext_mute_n | ~reg_mute_n;

  always_comb begin
    mix_nxt = mix_outputs(auto_muted, ext_req, mute_def, c4_follow, c4_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_q <= '0;
    end else begin
      mix_q <= mix_nxt;
    end
  end

  assign mute_digital  = mix_q.mute_digital;
  assign select_fm     = mix_q.select_fm;
  assign mute_pin_pull = ~reg_mute_n;
endmodule

// File: rtl/amute_ctrl_chk.sv
module amute_ctrl_chk #(
  parameter int unsigned ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_pulse,
  input logic [ERR_W-1:0] lim_upper,
  input logic [ERR_W-1:0] lim_lower,
  input logic             auto_off,
  input logic             ext_mute_n,
  input logic             reg_mute_n,
  input logic             c4_follow,
  input logic             c4_bit,
  input logic             mute_digital,
  input logic             select_fm,
  input logic             auto_muted,
  input logic             win_end,
  input logic [ERR_W-1:0] err_cnt,
  input logic             engage_ev,
  input logic             release_ev
);
  localparam logic [ERR_W-1:0] TOP = '1;

  p_change_at_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(auto_muted) |-> $past(engage_ev || release_ev || auto_off));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == TOP && !win_end) |=> err_cnt == TOP);

  p_engage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !auto_off && err_cnt >= lim_upper) |=> auto_muted);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !auto_off && err_cnt <= lim_lower && err_cnt < lim_upper) |=> !auto_muted);

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && err_pulse) |=> err_cnt == {{(ERR_W-1){1'b0}}, 1'b1});

  p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    auto_off |=> !auto_muted);

  p_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mute_n || !reg_mute_n) |=> mute_digital);

  p_c4_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c4_follow && !c4_bit) |=> select_fm);

  p_auto_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    auto_muted |=> (mute_digital && select_fm));
endmodule

bind amute_ctrl amute_ctrl_chk #(.ERR_W(ERR_W)) u_chk (.*);

// File: tb/amute_ctrl_tb.sv
`timescale 1ns/1ps
module amute_ctrl_tb;
  localparam int unsigned WIN = 4;

  logic clk = 0, rst_n = 0;
  logic tick_en = 0, err_pulse = 0;
  logic [7:0] lim_upper = 8'd6, lim_lower = 8'd3;
  logic auto_off = 0, ext_mute_n = 1, reg_mute_n = 1, mute_def = 0;
  logic c4_follow = 0, c4_bit = 1;
  logic mute_digital, select_fm, auto_muted, mute_pin_pull;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_t = 0, m_cnt = 0;
  bit m_auto = 0, e_md = 0, e_fm = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  amute_ctrl #(.TICK_HZ(1000), .WINDOW_MS(WIN), .ERR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .err_pulse(err_pulse),
    .lim_upper(lim_upper), .lim_lower(lim_lower), .auto_off(auto_off),
    .ext_mute_n(ext_mute_n), .reg_mute_n(reg_mute_n), .mute_def(mute_def),
    .c4_follow(c4_follow), .c4_bit(c4_bit), .mute_digital(mute_digital),
    .select_fm(select_fm), .auto_muted(auto_muted), .mute_pin_pull(mute_pin_pull)
  );

  task automatic chk(input string t, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  // One clock: drive, update the expected state at the edge, compare at negedge
  task automatic step(input bit e, input bit t);
    bit req, wend;
    err_pulse = e;
    tick_en = t;
    @(posedge clk);
    req  = !ext_mute_n || !reg_mute_n;
    e_md = m_auto || req;
    e_fm = m_auto || (req && mute_def) || (c4_follow && !c4_bit);
    wend = t && (m_t == WIN - 1);
    if (t) m_t = wend ? 0 : m_t + 1;
    if (auto_off) m_auto = 0;
    else if (wend) begin
      if (m_cnt >= int'(lim_upper)) m_auto = 1;
      else if (m_cnt <= int'(lim_lower)) m_auto = 0;
    end
    if (wend) m_cnt = e ? 1 : 0;
    else if (e && m_cnt < 255) m_cnt++;
    @(negedge clk);
    chk(tag, "auto_muted", auto_muted, m_auto);
    chk(tag, "mute_digital", mute_digital, e_md);
    chk(tag, "select_fm", select_fm, e_fm);
    chk(tag, "mute_pin_pull", mute_pin_pull, !reg_mute_n);
  endtask

  task automatic run_window(input int n, input int spacing);
    for (int c = 0; c < WIN * spacing; c++)
      step(c < n, (c % spacing) == spacing - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "auto_muted", auto_muted, 0);
    chk("R1", "mute_digital", mute_digital, 0);
    chk("R1", "select_fm", select_fm, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "mute_digital after release", mute_digital, 0);

    // R2: no decision before the last tick of the window
    tag = "R2";
    for (int c = 0; c < 9; c++) step(1, (c % 3) == 2);
    chk("R2", "held before boundary", auto_muted, 0);
    step(0, 0); step(0, 0); step(0, 1);
    chk("R2", "set on closing tick", auto_muted, 1);

    // R4 R5 R11: every total from both starting states
    tag = "R4 R5 R11";
    for (int n = 0; n <= 9; n++) begin
      run_window(8, 3);
      run_window(n, 3);
      chk("R5", "from muted", auto_muted, n > 3);
      run_window(0, 3);
      run_window(n, 3);
      chk("R4", "from clear", auto_muted, n >= 6);
    end
    // R4 priority when the limits overlap
    lim_upper = 8'd4; lim_lower = 8'd5;
    run_window(4, 3);
    chk("R4", "overlap engages", auto_muted, 1);
    lim_upper = 8'd6; lim_lower = 8'd3;
    run_window(0, 3);

    // R6: error on the closing tick belongs to the next window
    tag = "R6";
    lim_upper = 8'd12;
    run_window(12, 3);
    chk("R6", "boundary error excluded", auto_muted, 0);
    run_window(11, 3);
    chk("R6", "boundary error carried", auto_muted, 1);
    run_window(0, 3);
    lim_upper = 8'd6;

    // R3: saturation at 255 over a long window
    tag = "R3";
    lim_upper = 8'd255; lim_lower = 8'd0;
    run_window(300, 100);
    chk("R3", "saturated total engages", auto_muted, 1);
    run_window(0, 100);
    chk("R3", "empty window releases", auto_muted, 0);
    lim_upper = 8'd6; lim_lower = 8'd3;

    // R7: disable clears and blocks the automatic path
    tag = "R7";
    run_window(8, 3);
    auto_off = 1;
    step(0, 0); step(0, 0);
    chk("R7", "cleared", auto_muted, 0);
    chk("R7", "no digital mute", mute_digital, 0);
    run_window(12, 3);
    chk("R7", "stays clear", auto_muted, 0);
    auto_off = 0;
    run_window(0, 3);

    // R8 R9 R10: all static control combinations
    for (int k = 0; k < 32; k++) begin
      tag = "R8 R9 R10";
      ext_mute_n = k[0]; reg_mute_n = k[1]; mute_def = k[2];
      c4_follow = k[3]; c4_bit = k[4];
      step(0, 0); step(0, 0);
      chk("R8", "digital mute", mute_digital, !k[0] || !k[1]);
      chk("R9", "pin pull", mute_pin_pull, !k[1]);
      chk("R10", "fm select", select_fm, ((!k[0] || !k[1]) && k[2]) || (k[3] && !k[4]));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule